// File: doc/BRIEF.md
# Serial Debug Instruction Executor

This block sits behind the byte-level shift register of a serial debug link. It decodes each received byte as an instruction and carries it out. A store instruction writes the next received byte into data space at the address held in a 16-bit pointer. The pointer can be left as it is or advanced by one after the write. A pointer-load instruction puts the next received byte into either the low or the high half of the pointer. Two direct I/O instructions carry a 6-bit address spread across the opcode bits. One reads an I/O location and returns the byte for serial read-out. The other writes the next received byte into an I/O location.

The executor has two states. In the opcode state it decodes the incoming byte. A store-type instruction moves it to the operand state, where the next valid byte is taken as data. An I/O read completes in the cycle its opcode arrives: the read strobe and address are driven combinationally, and the returned byte is presented on the output for one cycle. Bytes that decode to nothing are dropped. Data-space and I/O writes leave the block as registered single-cycle strobes that carry both address and data.

Top module: `dbg_exec`

## Requirements
- R1: The synchronous active-high reset `rst` clears the pointer to 0x0000 and returns the executor to the opcode state. While reset is held, and in the first cycle after it, `ds_we`, `io_we` and `tx_valid` are low.
- R2: Opcode 0x60 takes the next received byte as data. In the cycle after that byte is accepted, the block pulses `ds_we` with `ds_addr` equal to the pointer and `ds_wdata` equal to the byte. The pointer is left unchanged.
- R3: Opcode 0x64 performs the same store as R2, at the pointer value before the increment, and then adds one to the pointer. The pointer wraps from 0xFFFF to 0x0000.
- R4: Opcode 0x68 loads the next received byte into pointer bits 7:0, and opcode 0x69 loads it into bits 15:8. The other half of the pointer keeps its value.
- R5: An opcode with bit 7 = 0 and bit 4 = 1 raises `io_rd` combinationally in the cycle the opcode is valid. In the next cycle `tx_valid` is high for exactly one cycle, and `tx_byte` holds the `io_rdata` value from the read cycle. No operand is consumed.
- R6: An opcode with bit 7 = 1 and bit 4 = 1 takes the next received byte as data. In the cycle after that byte is accepted, the block pulses `io_we` with `io_wdata` equal to the byte.
- R7: The 6-bit I/O address for R5 and R6 is {opcode[6:5], opcode[3:0]}, and it is driven on `io_raddr` or `io_waddr` respectively.
- R8: A byte with bit 4 = 0 that is not 0x60, 0x64, 0x68 or 0x69 produces no strobe, leaves the pointer unchanged, and keeps the executor in the opcode state, so the next byte is decoded as an opcode.
- R9: Cycles with `rx_valid` low change nothing. An instruction waiting in the operand state keeps waiting for its data byte, however many idle cycles pass.
- R10: `ds_we` and `io_we` are never high together, and each write strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte from the shift register |
| tx_valid | output | 1 | One-cycle strobe: read-out byte is valid |
| tx_byte | output | 8 | Byte for serial read-out |
| ds_we | output | 1 | Data-space write strobe |
| ds_addr | output | 16 | Data-space write address |
| ds_wdata | output | 8 | Data-space write data |
| io_rd | output | 1 | I/O read strobe (combinational) |
| io_raddr | output | 6 | I/O read address |
| io_rdata | input | 8 | I/O read data, returned in the same cycle |
| io_we | output | 1 | I/O write strobe |
| io_waddr | output | 6 | I/O write address |
| io_wdata | output | 8 | I/O write data |

## Verification
The assertions check the following on every cycle:
- write strobes never coincide and never last longer than one cycle;
- each write carries the byte received one cycle earlier;
- a read strobe appears only for an opcode of the read form, at the scattered address;
- every read-out pulse is paired with the read one cycle before it.

The bench's sweeps are needed for everything else. They show which pointer value each store lands on, through post-increments, half loads and the 0xFFFF wrap. They also show that each of the 124 undecoded bytes leaves no trace, and that idle gaps do not disturb a pending operand.

// File: rtl/dbg_exec_pkg.sv
package dbg_exec_pkg;

    localparam int BYTE_W = 8;
    localparam int IOA_W  = 6;

    localparam logic [BYTE_W-1:0] OPC_STORE     = 8'h60;
    localparam logic [BYTE_W-1:0] OPC_STORE_INC = 8'h64;
    localparam logic [6:0]        OPC_PLOAD_TOP = 7'b0110_100;

    typedef enum logic {
        ST_OPCODE,
        ST_OPERAND
    } exec_state_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_STORE,
        K_STORE_INC,
        K_PLOAD,
        K_IO_IN,
        K_IO_OUT
    } op_kind_e;

    typedef struct packed {
        op_kind_e           kind;
        logic               sel_hi;
        logic [IOA_W-1:0]   ioa;
    } op_dec_t;

    function automatic logic [IOA_W-1:0] io_addr_of(input logic [BYTE_W-1:0] op);
        return {op[6:5], op[3:0]};
    endfunction

    function automatic logic needs_operand(input op_kind_e k);
        return (k == K_STORE) || (k == K_STORE_INC) || (k == K_PLOAD) || (k == K_IO_OUT);
    endfunction

    function automatic op_dec_t decode_op(input logic [BYTE_W-1:0] op);
        op_dec_t d;
        d.kind   = K_NONE;
        d.sel_hi = op[0];
        d.ioa    = io_addr_of(op);
        if (op[4]) begin
            d.kind = op[7] ? K_IO_OUT : K_IO_IN;
        end else if (op == OPC_STORE) begin
            d.kind = K_STORE;
        end else if (op == OPC_STORE_INC) begin
            d.kind = K_STORE_INC;
        end else if (op[7:1] == OPC_PLOAD_TOP) begin
            d.kind = K_PLOAD;
        end
        return d;
    endfunction

endpackage

// File: rtl/dbg_exec_decode.sv
module dbg_exec_decode
    import dbg_exec_pkg::*;
(
    input  logic [BYTE_W-1:0] op,
    output op_dec_t           dec,
    output logic              has_operand
);
    always_comb begin
        dec         = decode_op(op);
        has_operand = needs_operand(dec.kind);
    end
endmodule

// File: rtl/dbg_exec_ptr.sv
module dbg_exec_ptr
    import dbg_exec_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ld_en,
    input  logic [SEL_W-1:0]    ld_sel,
    input  logic [BYTE_W-1:0]   ld_byte,
    input  logic                inc_en,
    output logic [PTR_W-1:0]    ptr
);
    localparam int N_LANES = PTR_W / BYTE_W;
    localparam int SEL_W   = (N_LANES > 1) ? $clog2(N_LANES) : 1;

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] loaded;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        assign loaded[g*BYTE_W +: BYTE_W] =
            (ld_en && (ld_sel == SEL_W'(g))) ? ld_byte : ptr_q[g*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (inc_en) begin
            ptr_q <= ptr_q + 1'b1;
        end else begin
            ptr_q <= loaded;
        end
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/dbg_exec_issue.sv
module dbg_exec_issue
    import dbg_exec_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ds_fire,
    input  logic [PTR_W-1:0]    ds_addr_in,
    input  logic                io_fire,
    input  logic [IOA_W-1:0]    io_addr_in,
    input  logic [BYTE_W-1:0]   wdata_in,
    input  logic                rd_fire,
    input  logic [BYTE_W-1:0]   rd_data_in,
    output logic                ds_we,
    output logic [PTR_W-1:0]    ds_addr,
    output logic [BYTE_W-1:0]   ds_wdata,
    output logic                io_we,
    output logic [IOA_W-1:0]    io_waddr,
    output logic [BYTE_W-1:0]   io_wdata,
    output logic                tx_valid,
    output logic [BYTE_W-1:0]   tx_byte
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ds_we    <= 1'b0;
            ds_addr  <= '0;
            ds_wdata <= '0;
            io_we    <= 1'b0;
            io_waddr <= '0;
            io_wdata <= '0;
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            ds_we    <= ds_fire;
            io_we    <= io_fire;
            tx_valid <= rd_fire;
            if (ds_fire) begin
                ds_addr  <= ds_addr_in;
                ds_wdata <= wdata_in;
            end
            if (io_fire) begin
                io_waddr <= io_addr_in;
                io_wdata <= wdata_in;
            end
            if (rd_fire) begin
                tx_byte <= rd_data_in;
            end
        end
    end
endmodule

// File: rtl/dbg_exec.sv
module dbg_exec
    import dbg_exec_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_valid,
    input  logic [7:0]          rx_byte,
    output logic                tx_valid,
    output logic [7:0]          tx_byte,
    output logic                ds_we,
    output logic [PTR_W-1:0]    ds_addr,
    output logic [7:0]          ds_wdata,
    output logic                io_rd,
    output logic [5:0]          io_raddr,
    input  logic [7:0]          io_rdata,
    output logic                io_we,
    output logic [5:0]          io_waddr,
    output logic [7:0]          io_wdata
);
    localparam int N_LANES = PTR_W / BYTE_W;
    localparam int SEL_W   = (N_LANES > 1) ? $clog2(N_LANES) : 1;

    exec_state_e      state_q;
    op_dec_t          pend_q;
    op_dec_t          dec;
    logic             dec_has_operand;
    logic [PTR_W-1:0] ptr;

    logic accept_op;
    logic operand_fire;
    logic rd_fire;
    logic ds_fire;
    logic io_fire;
    logic ld_en;
    logic inc_en;

    dbg_exec_decode u_decode (
        .op          (rx_byte),
        .dec         (dec),
        .has_operand (dec_has_operand)
    );

    always_comb begin
        accept_op    = rx_valid && (state_q == ST_OPCODE) && !rst;
        operand_fire = rx_valid && (state_q == ST_OPERAND);
        rd_fire      = accept_op && (dec.kind == K_IO_IN);
        ds_fire      = operand_fire && ((pend_q.kind == K_STORE) || (pend_q.kind == K_STORE_INC));
        io_fire      = operand_fire && (pend_q.kind == K_IO_OUT);
        ld_en        = operand_fire && (pend_q.kind == K_PLOAD);
        inc_en       = operand_fire && (pend_q.kind == K_STORE_INC);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OPCODE;
            pend_q  <= '{kind: K_NONE, sel_hi: 1'b0, ioa: '0};
        end else begin
            case (state_q)
                ST_OPCODE: begin
                    if (accept_op && dec_has_operand) begin
                        state_q <= ST_OPERAND;
                        pend_q  <= dec;
                    end
                end
                ST_OPERAND: begin
                    if (operand_fire) begin
                        state_q <= ST_OPCODE;
                    end
                end
                default: state_q <= ST_OPCODE;
            endcase
        end
    end

    dbg_exec_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .ld_sel  (SEL_W'(pend_q.sel_hi)),
        .ld_byte (rx_byte),
        .inc_en  (inc_en),
        .ptr     (ptr)
    );

    dbg_exec_issue #(.PTR_W(PTR_W)) u_issue (
        .clk        (clk),
        .rst        (rst),
        .ds_fire    (ds_fire),
        .ds_addr_in (ptr),
        .io_fire    (io_fire),
        .io_addr_in (pend_q.ioa),
        .wdata_in   (rx_byte),
        .rd_fire    (rd_fire),
        .rd_data_in (io_rdata),
        .ds_we      (ds_we),
        .ds_addr    (ds_addr),
        .ds_wdata   (ds_wdata),
        .io_we      (io_we),
        .io_waddr   (io_waddr),
        .io_wdata   (io_wdata),
        .tx_valid   (tx_valid),
        .tx_byte    (tx_byte)
    );

    assign io_rd    = rd_fire;
    assign io_raddr = dec.ioa;
endmodule

// File: rtl/dbg_exec_chk.sv
module dbg_exec_chk #(
    parameter int PTR_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_valid,
    input logic [7:0]       rx_byte,
    input logic             tx_valid,
    input logic [7:0]       tx_byte,
    input logic             ds_we,
    input logic [PTR_W-1:0] ds_addr,
    input logic [7:0]       ds_wdata,
    input logic             io_rd,
    input logic [5:0]       io_raddr,
    input logic [7:0]       io_rdata,
    input logic             io_we,
    input logic [5:0]       io_waddr,
    input logic [7:0]       io_wdata
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!ds_we && !io_we && !tx_valid));

    // R2
    ds_data_chk: assert property (@(posedge clk) disable iff (rst)
        ds_we |-> ($past(rx_valid) && ds_wdata == $past(rx_byte)));

    // R6
    io_data_chk: assert property (@(posedge clk) disable iff (rst)
        io_we |-> ($past(rx_valid) && io_wdata == $past(rx_byte)));

    // R5
    rd_form_chk: assert property (@(posedge clk) disable iff (rst)
        io_rd |-> (rx_valid && !rx_byte[7] && rx_byte[4]));

    // R7
    rd_addr_chk: assert property (@(posedge clk) disable iff (rst)
        io_rd |-> (io_raddr == {rx_byte[6:5], rx_byte[3:0]}));

    // R5
    rd_return_chk: assert property (@(posedge clk) disable iff (rst)
        io_rd |=> (tx_valid && tx_byte == $past(io_rdata)));

    // R5
    tx_origin_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(io_rd));

    // R10
    wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ds_we, io_we}));

    // R10
    ds_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ds_we |=> !ds_we);

    // R10
    io_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        io_we |=> !io_we);
endmodule

bind dbg_exec dbg_exec_chk #(.PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .tx_valid (tx_valid),
    .tx_byte  (tx_byte),
    .ds_we    (ds_we),
    .ds_addr  (ds_addr),
    .ds_wdata (ds_wdata),
    .io_rd    (io_rd),
    .io_raddr (io_raddr),
    .io_rdata (io_rdata),
    .io_we    (io_we),
    .io_waddr (io_waddr),
    .io_wdata (io_wdata)
);

// File: tb/test_dbg_exec.sv
`timescale 1ns/1ps
module test_dbg_exec;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        ds_we;
    logic [15:0] ds_addr;
    logic [7:0]  ds_wdata;
    logic        io_rd;
    logic [5:0]  io_raddr;
    logic [7:0]  io_rdata;
    logic        io_we;
    logic [5:0]  io_waddr;
    logic [7:0]  io_wdata;

    int total = 0;
    int fails = 0;
    logic        cap_rd;
    logic [5:0]  cap_raddr;
    logic [15:0] ptr_m;

    always #4 clk = ~clk;

    function automatic logic [7:0] io_model(input logic [5:0] a);
        return {a, 2'b01} ^ 8'h3C;
    endfunction

    assign io_rdata = io_model(io_raddr);

    dbg_exec i_dbg_exec (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_valid(tx_valid), .tx_byte(tx_byte),
        .ds_we(ds_we), .ds_addr(ds_addr), .ds_wdata(ds_wdata),
        .io_rd(io_rd), .io_raddr(io_raddr), .io_rdata(io_rdata),
        .io_we(io_we), .io_waddr(io_waddr), .io_wdata(io_wdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        #1;
        cap_rd    = io_rd;
        cap_raddr = io_raddr;
        @(posedge clk);
        #1;
        rx_valid = 1'b0;
        rx_byte  = 8'h00;
    endtask

    task automatic quiet_cycle(input string req);
        @(negedge clk);
        chk(req, {29'd0, ds_we, io_we, tx_valid}, 32'd0);
    endtask

    task automatic do_store(input logic [7:0] op, input logic [7:0] d,
                            input int gap, input string req);
        drive_byte(op);
        chk(req, {31'd0, cap_rd}, 32'd0);
        for (int i = 0; i < gap; i++) quiet_cycle("R9");
        drive_byte(d);
        @(negedge clk);
        chk(req, {15'd0, ds_we, ds_addr}, {15'd0, 1'b1, ptr_m});
        chk(req, {24'd0, ds_wdata}, {24'd0, d});
        chk("R10", {31'd0, io_we}, 32'd0);
        if (op == 8'h64) ptr_m = ptr_m + 16'd1;
        @(negedge clk);
        chk("R10", {31'd0, ds_we}, 32'd0);
    endtask

    task automatic do_pload(input logic hi, input logic [7:0] d);
        drive_byte({7'b0110_100, hi});
        drive_byte(d);
        quiet_cycle("R4");
        if (hi) ptr_m[15:8] = d;
        else    ptr_m[7:0]  = d;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        ptr_m = 16'h0000;
        // R1: reset held with traffic present
        rx_valid = 1'b1;
        rx_byte  = 8'h60;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", {29'd0, ds_we, io_we, tx_valid}, 32'd0);
        rx_valid = 1'b0;
        rst = 1'b0;
        quiet_cycle("R1");
        // R1: pointer starts at zero
        do_store(8'h60, 8'hC3, 0, "R1");

        // R4, R2: pointer half loads
        do_pload(1'b0, 8'h34);
        do_pload(1'b1, 8'h12);
        do_store(8'h60, 8'h11, 0, "R2");
        do_store(8'h60, 8'h22, 2, "R2");
        // R3: post increment
        for (int i = 0; i < 3; i++) do_store(8'h64, 8'(8'h40 + i), i, "R3");
        do_store(8'h60, 8'h55, 0, "R3");
        do_pload(1'b0, 8'hFF);
        do_store(8'h64, 8'h66, 0, "R4");
        do_store(8'h60, 8'h77, 0, "R3");
        // R3: wrap
        do_pload(1'b1, 8'hFF);
        do_pload(1'b0, 8'hFF);
        do_store(8'h64, 8'h88, 0, "R3");
        chk("R3", {16'd0, ptr_m}, 32'd0);
        do_store(8'h60, 8'h99, 3, "R3");

        // R5, R7: every I/O read address
        for (int a = 0; a < 64; a++) begin
            logic [5:0] aa;
            aa = 6'(a);
            drive_byte({1'b0, aa[5:4], 1'b1, aa[3:0]});
            chk("R5", {31'd0, cap_rd}, 32'd1);
            chk("R7", {26'd0, cap_raddr}, {26'd0, aa});
            @(negedge clk);
            chk("R5", {23'd0, tx_valid, tx_byte}, {23'd0, 1'b1, io_model(aa)});
            @(negedge clk);
            chk("R5", {31'd0, tx_valid}, 32'd0);
        end

        // R6, R7: every I/O write address
        for (int a = 0; a < 64; a++) begin
            logic [5:0] aa;
            aa = 6'(a);
            drive_byte({1'b1, aa[5:4], 1'b1, aa[3:0]});
            chk("R6", {31'd0, cap_rd}, 32'd0);
            if (a % 7 == 0) quiet_cycle("R9");
            drive_byte({2'b10, aa} ^ 8'hA5);
            @(negedge clk);
            chk("R6", {23'd0, io_we, io_wdata}, {23'd0, 1'b1, {2'b10, aa} ^ 8'hA5});
            chk("R7", {26'd0, io_waddr}, {26'd0, aa});
            chk("R10", {31'd0, ds_we}, 32'd0);
            @(negedge clk);
            chk("R10", {31'd0, io_we}, 32'd0);
        end

        // R8: every undecoded byte is dropped
        for (int b = 0; b < 256; b++) begin
            logic [7:0] bb;
            bb = 8'(b);
            if (!bb[4] && bb != 8'h60 && bb != 8'h64 && bb != 8'h68 && bb != 8'h69) begin
                drive_byte(bb);
                chk("R8", {31'd0, cap_rd}, 32'd0);
                quiet_cycle("R8");
                do_store(8'h60, bb ^ 8'h5A, 0, "R8");
            end
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule